// File: doc/BRIEF.md
# LoRaWAN Receive Slot Scheduler

This block opens one downlink receive slot after each uplink. A one-cycle `tx_done` pulse starts it. The block then counts microsecond ticks from a free-running time base. The gateway starts its downlink preamble a fixed delay after the uplink ends. The scheduler turns the receiver on so that the window overlaps that preamble by enough symbols, even when the local oscillator has drifted by up to a programmed error bound in either direction.

In chirp mode the symbol time follows from the spreading factor and the bandwidth select. The window must cover two symbols plus twice the error bound. It is rounded up to whole symbols and never falls below five. The open instant is the midpoint of the earliest and latest valid starts, which is four symbols after the preamble start less half the window. This midpoint can fall before or after the preamble start. In FSK mode the window is a fixed 1300 µs overlap plus twice the error bound, centred on the preamble start.

The open instant is measured relative to the expected preamble. The receive enable stays high for the window length. It is held beyond the window only when a preamble is reported, and it is then released at the end of the frame.

Top module: `rx_slot_sched`

## Requirements
- R1: In chirp mode (`fsk_mode`=0) with a valid configuration, `tsymb_us` equals 2^sf·8 when `bw_sel`=0 (125 kHz) and 2^sf·4 when `bw_sel`=1 (250 kHz). It is 0 in FSK mode and on a configuration error.
- R2: In chirp mode with a valid configuration, `win_sym` equals ceil((2·T + 2·`err_us`)/T), where T is `tsymb_us`, with a floor of 5. `win_us` equals `win_sym`·T.
- R3: `offset_us` is a two's-complement value equal to 4·T − `win_us`/2. A negative value means the receiver opens before the preamble start.
- R4: In FSK mode, `win_us` is 1300 + 2·`err_us`, `offset_us` is −`win_us`/2, and `win_sym` and `tsymb_us` are 0. The `sf` and `bw_sel` inputs have no effect in this mode.
- R5: In chirp mode, `config_error` is high when `sf` is below 7 or above 12, or when `bw_sel`=1 with `sf` other than 7. A `tx_done` pulse during a configuration error starts no slot: `rx_enable` and `timeout` stay low.
- R6: Let the open count be DELAY_US + `offset_us`, clamped at 0. With `tick_us` held high, `rx_enable` is first seen high that many cycles after the cycle following the `tx_done` cycle.
- R7: Only cycles with `tick_us` high advance the slot timing. While `tick_us` is low, `rx_enable` does not rise.
- R8: With no preamble, `rx_enable` stays high for `win_us` ticks. In the first cycle after it drops, `timeout` pulses high for exactly one cycle.
- R9: A `preamble_detected` pulse while `rx_enable` is high keeps `rx_enable` high past the window end with no `timeout`. The first `frame_done` then drops `rx_enable` in the next cycle, again without `timeout`.
- R10: A `tx_done` pulse while a slot is in progress (waiting or open) is ignored and does not change the slot's timing.
- R11: Under reset, `rx_enable` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle microsecond time base strobe |
| tx_done | input | 1 | End-of-uplink pulse; starts a slot |
| fsk_mode | input | 1 | 1 selects the FSK slot rule, 0 the chirp rule |
| sf | input | 4 | Spreading factor, 7 to 12 |
| bw_sel | input | 1 | 0 selects 125 kHz, 1 selects 250 kHz |
| err_us | input | ERR_W | Timing-error bound in microseconds |
| preamble_detected | input | 1 | Radio reports a detected preamble |
| frame_done | input | 1 | Radio reports end of the received frame |
| rx_enable | output | 1 | Receiver on |
| timeout | output | 1 | One-cycle pulse when the window closes with no preamble |
| config_error | output | 1 | Invalid chirp configuration |
| tsymb_us | output | TIME_W | Symbol duration in microseconds |
| win_sym | output | SYM_W | Window length in symbols |
| win_us | output | TIME_W | Window length in microseconds |
| offset_us | output | TIME_W+2 | Signed open offset relative to the preamble start |

## Verification
A wrong rounding or floor in the window arithmetic shows at once on `win_sym`, `win_us` and `offset_us`, because these outputs follow the configuration inputs combinationally. A broken comparison in the slot counter is only visible later, as an `rx_enable` edge that arrives one or more ticks early or late, either thousands of cycles after `tx_done` or at the window end. The bench therefore measures the exact cycle of both edges. A state machine that mishandles preamble, frame-end or retrigger events shows up as a spurious or missing `timeout` pulse, or as a slot that restarts. These faults appear within one cycle of the window boundary, or in the next delay measurement.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_OPEN = 2'd2,
    SLOT_HOLD = 2'd3
  } slot_state_e;

  localparam int unsigned SF_LO         = 7;
  localparam int unsigned SF_HI         = 12;
  localparam int unsigned SF_WIDE_ONLY  = 7;
  localparam int unsigned MIN_WIN_SYM   = 5;
  localparam int unsigned NARROW_SHIFT  = 3;  // 125 kHz: T = 2^sf * 8 us
endpackage

// File: rtl/rxs_symcalc.sv
module rxs_symcalc
  import rxs_pkg::*;
#(
  parameter int unsigned TIME_W = 18
) (
  input  logic [3:0]        sf,
  input  logic              bw_sel,
  input  logic              fsk_mode,
  output logic [3:0]        sym_shift,
  output logic [TIME_W-1:0] tsymb,
  output logic              cfg_err
);
  logic sf_bad;

  always_comb begin
    sf_bad = (sf < 4'(SF_LO)) || (sf > 4'(SF_HI)) ||
             (bw_sel && (sf != 4'(SF_WIDE_ONLY)));
    cfg_err   = !fsk_mode && sf_bad;
    // log2 of symbol time in us: sf + 3 at 125 kHz, sf + 2 at 250 kHz
    sym_shift = sf + 4'(NARROW_SHIFT) - {3'b000, bw_sel};
    tsymb     = '0;
    if (!fsk_mode && !sf_bad) begin
      tsymb = TIME_W'(1) << sym_shift;
    end
  end
endmodule

// File: rtl/rxs_window.sv
module rxs_window
  import rxs_pkg::*;
#(
  parameter int unsigned ERR_W          = 16,
  parameter int unsigned TIME_W         = 18,
  parameter int unsigned SYM_W          = 9,
  parameter int unsigned FSK_OVERLAP_US = 1300
) (
  input  logic [ERR_W-1:0]         err_us,
  input  logic [3:0]               sym_shift,
  input  logic [TIME_W-1:0]        tsymb,
  input  logic                     fsk_mode,
  output logic [SYM_W-1:0]         win_sym,
  output logic [TIME_W-1:0]        win_us,
  output logic signed [TIME_W+1:0] ofs_us
);
  localparam int unsigned SUM_W  = (ERR_W + 2 > TIME_W + 1) ? ERR_W + 2 : TIME_W + 1;
  localparam int unsigned WIDE_W = SYM_W + 16;
  localparam int unsigned OFS_W  = TIME_W + 2;

  logic [ERR_W:0]        two_err;
  logic [SUM_W-1:0]      rnd_sum;
  logic [SUM_W-1:0]      ceil_q;
  logic [SUM_W-1:0]      nsym_raw;
  logic [SUM_W-1:0]      nsym;
  logic                  sym_ok;
  logic [WIDE_W-1:0]     win_wide;
  logic [OFS_W-1:0]      four_sym;
  logic [OFS_W-1:0]      half_win;

  always_comb begin
    two_err  = {err_us, 1'b0};
    sym_ok   = (tsymb != '0);
    // Symbol time is a power of two: ceiling division is add-and-shift.
    rnd_sum  = SUM_W'(two_err) + SUM_W'(tsymb) - SUM_W'(1);
    ceil_q   = rnd_sum >> sym_shift;
    nsym_raw = ceil_q + SUM_W'(2);
    nsym     = (nsym_raw < SUM_W'(MIN_WIN_SYM)) ? SUM_W'(MIN_WIN_SYM) : nsym_raw;

    win_sym  = '0;
    win_wide = '0;
    if (fsk_mode) begin
      win_wide = WIDE_W'(FSK_OVERLAP_US) + WIDE_W'(two_err);
    end else if (sym_ok) begin
      win_sym  = SYM_W'(nsym);
      win_wide = WIDE_W'(SYM_W'(nsym)) << sym_shift;
    end
    win_us   = TIME_W'(win_wide);

    four_sym = {2'b00, tsymb} << 2;
    half_win = {2'b00, win_us} >> 1;
    ofs_us   = $signed(four_sym) - $signed(half_win);
  end
endmodule

// File: rtl/rxs_sequencer.sv
module rxs_sequencer
  import rxs_pkg::*;
#(
  parameter int unsigned TIME_W   = 18,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned DELAY_US = 1000000,
  localparam int unsigned OFS_W   = TIME_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    tx_done,
  input  logic                    preamble_det,
  input  logic                    frame_done,
  input  logic                    cfg_err,
  input  logic [TIME_W-1:0]       win_us,
  input  logic signed [OFS_W-1:0] ofs_us,
  output logic                    rx_enable,
  output logic                    timeout,
  output logic                    busy
);
  localparam int unsigned       EXT_W   = CNT_W + 2;
  localparam logic [CNT_W-1:0]  DELAY_V = CNT_W'(DELAY_US);

  slot_state_e             state_q, state_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [CNT_W-1:0]        tgt_q;
  logic [TIME_W-1:0]       win_q;
  logic                    timeout_q, timeout_d;
  logic                    load_en;
  logic signed [EXT_W-1:0] ofs_ext;
  logic signed [EXT_W-1:0] open_sum;
  logic [CNT_W-1:0]        open_at;
  logic [CNT_W-1:0]        win_ext;

  // Ticks from TX-done to opening: fixed delay plus signed offset, floor 0.
  always_comb begin
    ofs_ext  = {{(EXT_W - OFS_W){ofs_us[OFS_W-1]}}, ofs_us};
    open_sum = $signed({2'b00, DELAY_V}) + ofs_ext;
    open_at  = open_sum[EXT_W-1] ? '0 : CNT_W'(open_sum);
    win_ext  = CNT_W'(win_q);
  end

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    timeout_d = 1'b0;
    load_en   = 1'b0;
    unique case (state_q)
      SLOT_IDLE: begin
        if (tx_done && !cfg_err) begin
          load_en = 1'b1;
          cnt_d   = '0;
          state_d = (open_at == '0) ? SLOT_OPEN : SLOT_WAIT;
        end
      end
      SLOT_WAIT: begin
        if (tick) begin
          if (cnt_q == tgt_q - 1'b1) begin
            state_d = SLOT_OPEN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SLOT_OPEN: begin
        if (preamble_det) begin
          state_d = SLOT_HOLD;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt_q == win_ext - 1'b1) begin
            state_d   = SLOT_IDLE;
            cnt_d     = '0;
            timeout_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SLOT_HOLD: begin
        if (frame_done) begin
          state_d = SLOT_IDLE;
        end
      end
      default: state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SLOT_IDLE;
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      timeout_q <= timeout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      win_q <= '0;
    end else if (load_en) begin
      tgt_q <= open_at;
      win_q <= win_us;
    end
  end

  assign rx_enable = (state_q == SLOT_OPEN) || (state_q == SLOT_HOLD);
  assign busy      = (state_q != SLOT_IDLE);
  assign timeout   = timeout_q;
endmodule

// File: rtl/rx_slot_sched.sv
module rx_slot_sched #(
  parameter int unsigned ERR_W          = 16,
  parameter int unsigned TIME_W         = 18,
  parameter int unsigned SYM_W          = 9,
  parameter int unsigned CNT_W          = 24,
  parameter int unsigned DELAY_US       = 1000000,
  parameter int unsigned FSK_OVERLAP_US = 1300,
  parameter bit          FSK_EN         = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_us,
  input  logic                     tx_done,
  input  logic                     fsk_mode,
  input  logic [3:0]               sf,
  input  logic                     bw_sel,
  input  logic [ERR_W-1:0]         err_us,
  input  logic                     preamble_detected,
  input  logic                     frame_done,
  output logic                     rx_enable,
  output logic                     timeout,
  output logic                     config_error,
  output logic [TIME_W-1:0]        tsymb_us,
  output logic [SYM_W-1:0]         win_sym,
  output logic [TIME_W-1:0]        win_us,
  output logic signed [TIME_W+1:0] offset_us
);
  logic       rst_meta_q, rst_sync_q;
  logic       fsk_eff;
  logic [3:0] sym_shift;
  logic       slot_busy;

  // Reset asserts asynchronously, releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  if (FSK_EN) begin : g_fsk
    assign fsk_eff = fsk_mode;
  end else begin : g_nofsk
    assign fsk_eff = 1'b0;
  end

  rxs_symcalc #(.TIME_W(TIME_W)) u_sym (
    .sf        (sf),
    .bw_sel    (bw_sel),
    .fsk_mode  (fsk_eff),
    .sym_shift (sym_shift),
    .tsymb     (tsymb_us),
    .cfg_err   (config_error)
  );

  rxs_window #(
    .ERR_W          (ERR_W),
    .TIME_W         (TIME_W),
    .SYM_W          (SYM_W),
    .FSK_OVERLAP_US (FSK_OVERLAP_US)
  ) u_win (
    .err_us    (err_us),
    .sym_shift (sym_shift),
    .tsymb     (tsymb_us),
    .fsk_mode  (fsk_eff),
    .win_sym   (win_sym),
    .win_us    (win_us),
    .ofs_us    (offset_us)
  );

  rxs_sequencer #(
    .TIME_W   (TIME_W),
    .CNT_W    (CNT_W),
    .DELAY_US (DELAY_US)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .tick         (tick_us),
    .tx_done      (tx_done),
    .preamble_det (preamble_detected),
    .frame_done   (frame_done),
    .cfg_err      (config_error),
    .win_us       (win_us),
    .ofs_us       (offset_us),
    .rx_enable    (rx_enable),
    .timeout      (timeout),
    .busy         (slot_busy)
  );
endmodule

// File: rtl/rx_slot_sched_chk.sv
module rx_slot_sched_chk #(
  parameter int unsigned TIME_W = 18,
  parameter int unsigned SYM_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_done,
  input logic              frame_done,
  input logic              fsk_mode,
  input logic              rx_enable,
  input logic              timeout,
  input logic              config_error,
  input logic              slot_busy,
  input logic [SYM_W-1:0]  win_sym,
  input logic [TIME_W-1:0] tsymb_us
);
  assert_min_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsk_mode && !config_error) |-> (win_sym >= SYM_W'(5)));

  assert_fsk_nosym_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fsk_mode |-> (win_sym == '0 && tsymb_us == '0));

  assert_cfg_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_busy && tx_done && config_error) |=> !slot_busy);

  assert_rx_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |-> slot_busy);

  assert_timeout_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  assert_timeout_after_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> ($past(rx_enable) && !rx_enable));

  assert_fall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_enable) |-> (timeout || $past(frame_done)));
endmodule

bind rx_slot_sched rx_slot_sched_chk #(.TIME_W(TIME_W), .SYM_W(SYM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_done      (tx_done),
  .frame_done   (frame_done),
  .fsk_mode     (fsk_eff),
  .rx_enable    (rx_enable),
  .timeout      (timeout),
  .config_error (config_error),
  .slot_busy    (slot_busy),
  .win_sym      (win_sym),
  .tsymb_us     (tsymb_us)
);

// File: tb/rx_slot_sched_tb.sv
module rx_slot_sched_tb;
  localparam int DLY = 2000;
  localparam int LIM = 100000;

  logic        clk;
  logic        rst_n;
  logic        tick_us;
  logic        tx_done;
  logic        fsk_mode;
  logic [3:0]  sf;
  logic        bw_sel;
  logic [15:0] err_us;
  logic        preamble_detected;
  logic        frame_done;
  logic        rx_enable;
  logic        timeout;
  logic        config_error;
  logic [17:0] tsymb_us;
  logic [8:0]  win_sym;
  logic [17:0] win_us;
  logic signed [19:0] offset_us;

  int n_vec;
  int n_bad;

  rx_slot_sched #(.DELAY_US(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tx_done(tx_done),
    .fsk_mode(fsk_mode), .sf(sf), .bw_sel(bw_sel), .err_us(err_us),
    .preamble_detected(preamble_detected), .frame_done(frame_done),
    .rx_enable(rx_enable), .timeout(timeout), .config_error(config_error),
    .tsymb_us(tsymb_us), .win_sym(win_sym), .win_us(win_us), .offset_us(offset_us)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit ref_cfg(int s, int b, int f);
    return (f == 0) && (s < 7 || s > 12 || (b == 1 && s != 7));
  endfunction

  function automatic longint ref_t(int s, int b, int f);
    if (f != 0 || ref_cfg(s, b, f)) return 0;
    return (b == 1) ? (longint'(4) << s) : (longint'(8) << s);
  endfunction

  function automatic longint ref_nsym(int s, int b, int f, int e);
    longint t = ref_t(s, b, f);
    longint n;
    if (t == 0) return 0;
    n = (2 * t + 2 * e + t - 1) / t;
    return (n < 5) ? 5 : n;
  endfunction

  function automatic longint ref_win(int s, int b, int f, int e);
    if (f != 0) return 1300 + 2 * e;
    return ref_nsym(s, b, f, e) * ref_t(s, b, f);
  endfunction

  function automatic longint ref_ofs(int s, int b, int f, int e);
    return 4 * ref_t(s, b, f) - ref_win(s, b, f, e) / 2;
  endfunction

  function automatic longint ref_open(int s, int b, int f, int e);
    longint v = DLY + ref_ofs(s, b, f, e);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int s, input int b, input int f, input int e);
    @(negedge clk);
    sf = 4'(s); bw_sel = b[0]; fsk_mode = f[0]; err_us = 16'(e);
    #1;
  endtask

  task automatic check_cfg(input int s, input int b, input int f, input int e);
    set_cfg(s, b, f, e);
    chk("R5", "config_error", longint'(config_error), longint'(ref_cfg(s, b, f)));
    if (!ref_cfg(s, b, f)) begin
      chk(f ? "R4" : "R1", "tsymb_us", longint'(tsymb_us), ref_t(s, b, f));
      chk(f ? "R4" : "R2", "win_sym", longint'(win_sym), ref_nsym(s, b, f, e));
      chk(f ? "R4" : "R2", "win_us", longint'(win_us), ref_win(s, b, f, e));
      chk(f ? "R4" : "R3", "offset_us", longint'(offset_us), ref_ofs(s, b, f, e));
    end
  endtask

  // mode 0: timeout, 1: preamble hold, 2: tick gap, 3: retrigger ignored
  task automatic run_slot(input int s, input int b, input int f, input int e, input int mode);
    longint exp_open = ref_open(s, b, f, e);
    longint exp_win  = ref_win(s, b, f, e);
    longint n = 0;
    longint m = 0;
    bit bad = 1'b0;
    set_cfg(s, b, f, e);
    tick_us = 1'b1;
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    if (mode == 2) begin
      tick_us = 1'b0;
      repeat (50) begin
        if (rx_enable) bad = 1'b1;
        @(negedge clk);
        n++;
      end
      tick_us = 1'b1;
      chk("R7", "rise during tick gap", longint'(bad), 0);
      exp_open += 50;
    end
    while (!rx_enable && n < LIM) begin
      tx_done = (mode == 3 && n == 3);
      @(negedge clk);
      n++;
    end
    tx_done = 1'b0;
    chk(mode == 2 ? "R7" : (mode == 3 ? "R10" : "R6"), "open delay", n, exp_open);
    if (mode == 1) begin
      repeat (3) @(negedge clk);
      preamble_detected = 1'b1;
      @(negedge clk);
      preamble_detected = 1'b0;
      bad = 1'b0;
      for (longint i = 0; i < exp_win + 20; i++) begin
        @(negedge clk);
        if (!rx_enable || timeout) bad = 1'b1;
      end
      chk("R9", "hold past window", longint'(bad), 0);
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
      chk("R9", "rx_enable after frame_done", longint'(rx_enable), 0);
      chk("R9", "timeout after frame_done", longint'(timeout), 0);
    end else begin
      while (rx_enable && m < LIM) begin
        tx_done = (mode == 3 && m == 5);
        @(negedge clk);
        m++;
      end
      tx_done = 1'b0;
      chk(mode == 3 ? "R10" : "R8", "window length", m, exp_win);
      chk("R8", "timeout pulse", longint'(timeout), 1);
      @(negedge clk);
      chk("R8", "timeout one cycle", longint'(timeout), 0);
      chk("R10", "no restart", longint'(rx_enable), 0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog: actual 190000 cycles expected completion sooner");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; tick_us = 1'b1; tx_done = 1'b0; fsk_mode = 1'b0;
    sf = 4'd7; bw_sel = 1'b0; err_us = '0;
    preamble_detected = 1'b0; frame_done = 1'b0;
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    chk("R11", "rx_enable in reset", longint'(rx_enable), 0);
    chk("R11", "timeout in reset", longint'(timeout), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "rx_enable after reset", longint'(rx_enable), 0);

    // Directed arithmetic corners
    check_cfg(7, 0, 0, 1500);   // 5 symbols, +1536
    check_cfg(7, 0, 0, 20000);  // 42 symbols, negative offset
    check_cfg(10, 0, 0, 20000); // 7 symbols, +4096
    check_cfg(12, 0, 0, 0);     // floor of 5
    check_cfg(7, 1, 0, 0);      // 250 kHz symbol
    check_cfg(7, 1, 0, 65535);  // widest window
    check_cfg(8, 1, 0, 100);    // invalid at 250 kHz
    check_cfg(6, 0, 0, 100);
    check_cfg(13, 0, 0, 100);
    check_cfg(6, 1, 1, 100);    // FSK ignores sf/bw
    check_cfg(9, 0, 1, 65535);
    for (int i = 0; i < 40; i++) begin
      check_cfg(int'($urandom_range(5, 14)), int'($urandom_range(0, 1)),
                int'($urandom_range(0, 3) == 0), int'($urandom_range(0, 65535)));
    end

    // Configuration error blocks a slot (R5)
    set_cfg(9, 1, 0, 0);
    chk("R5", "config_error set", longint'(config_error), 1);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    begin
      bit seen = 1'b0;
      repeat (200) begin
        @(negedge clk);
        if (rx_enable || timeout) seen = 1'b1;
      end
      chk("R5", "slot under config error", longint'(seen), 0);
    end

    // Directed slots
    run_slot(7, 0, 0, 1500, 0);
    run_slot(7, 0, 0, 1500, 2);
    run_slot(8, 0, 0, 0, 3);
    run_slot(7, 0, 1, 0, 1);
    run_slot(7, 0, 1, 3000, 0);   // negative open clamps to 0
    run_slot(7, 1, 0, 500, 0);

    // Random slots
    for (int i = 0; i < 5; i++) begin
      int md = int'($urandom_range(0, 3));
      int fs = (md < 2) ? int'($urandom_range(0, 2) == 0) : 0;
      run_slot(int'($urandom_range(7, 8)), 0, fs, int'($urandom_range(0, 3000)), md);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule